// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block sends one SD command at a time and collects the card's reply. Software loads a 32-bit argument, then writes a 16-bit command word. That write starts the command. The block serialises a 48-bit frame, with its CRC7, onto the command line, one bit per clock, starting with the most significant bit. It then listens on the command input for a reply of the length the command word asks for: none, 48 bits or 136 bits. The payload of the reply goes into a 128-bit response register.

A present-state word tells software when a new command may be issued. Two status words report the outcome: completion and a summary flag in one, the individual error causes in the other. A command whose reply is followed by busy signalling, and which moves no data, holds a separate data-inhibit flag until the card releases data line 0. The bit clock is the block's own clock, so one cycle is one bit on the wire.

Top module: `sd_cmd_issuer`

## Requirements
- R1: A command-word write accepted while idle sends, from the cycle after the write, 48 bits MSB first. The bits are a 0 start bit, a 1 direction bit, the index taken from command bits [13:8], the 32-bit argument, CRC7 and a 1 end bit. The command output rests at 1 when nothing is sent.
- R2: The CRC7 uses the polynomial x^7+x^3+1 with an all-zero start value. It covers the first 40 bits of the frame. An index-0 command with a zero argument therefore carries CRC 7'h4A.
- R3: Present-state bit 0 (command busy) is 1 from the cycle after acceptance until the exchange ends. A command-word write while it is 1 is ignored, and no second frame follows.
- R4: Response type 2'b00 in command bits [1:0] waits for no reply. Command busy drops, and interrupt-status bit 0 (complete) rises, one cycle after the end bit leaves.
- R5: Type 2'b10 (48-bit) and type 2'b11 (48-bit then busy) load response[31:0] with received frame bits [39:8] and clear the bits above. Completion is set when the reply ends.
- R6: Type 2'b01 (136-bit) loads response[119:0] with received frame bits [127:8], which drops the CRC/end byte. Response bits [127:120] are 0.
- R7: Type 2'b11 with command bit 5 (data present) clear sets present-state bit 1 (data busy) on acceptance. Data busy clears only after the reply, once data line 0 is high. While data busy is set, another such command is ignored. With bit 5 set, data busy is not raised. Present-state bit 20 mirrors data line 0.
- R8: If no 0 start bit arrives within TMO_CYCLES cycles after the end bit, error-status bit 0 is set. Completion is not set, and both busy flags clear. A reply that starts 60 cycles after the end bit is still accepted.
- R9: With command bit 4 set, a 48-bit reply whose index field (frame bits [45:40]) differs from the sent index sets error-status bit 3. With bit 4 clear, no error is raised.
- R10: With command bit 3 set, a 48-bit reply whose bits [7:1] differ from the CRC7 of its bits [47:8] sets error-status bit 1.
- R11: Status bits are cleared by writing 1 to them. Interrupt-status bit 15 is 1 exactly when any error-status bit is set, and clears only with them.
- R12: After reset, the command output is 1. Present state shows only bit 20, and the status words and response are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| arg_we | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument write data |
| cmd_we | input | 1 | Command word write strobe, starts a command |
| cmd_wdata | input | 16 | Command word |
| int_clr_we | input | 1 | Interrupt-status clear strobe |
| int_clr | input | 16 | Interrupt-status bits to clear |
| err_clr_we | input | 1 | Error-status clear strobe |
| err_clr | input | 16 | Error-status bits to clear |
| cmd_in | input | 1 | Command line from the card |
| dat0_in | input | 1 | Data line 0 level |
| cmd_out | output | 1 | Command line to the card |
| present_state | output | 32 | Busy flags and data line 0 level |
| int_status | output | 16 | Completion and error summary |
| err_status | output | 16 | Timeout, CRC and index error causes |
| response | output | 128 | Stored reply payload |

## Verification
The bench builds the block with TMO_CYCLES left at 64. With that setting, a responder that answers after 3 cycles, one that answers after 60 cycles and a silent one cover both sides of the reply window within a short run. The response table combines each response length with index and CRC checking turned on and off, and with corrupted replies. It confirms the known CRC of a zero-argument index-0 command. Directed steps hold data line 0 low to exercise the data-busy hold and the rejection of a command while it is held.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int ARG_W   = 32;
    localparam int IDX_W   = 6;
    localparam int CRC_W   = 7;
    localparam int SHORT_W = 48;
    localparam int LONG_W  = 136;
    localparam int RSP_W   = 128;
    localparam int CRC_SPAN = SHORT_W - 8;

    // status / present-state bit positions
    localparam int PS_CMD_BUSY = 0;
    localparam int PS_DAT_BUSY = 1;
    localparam int PS_DAT0     = 20;
    localparam int IS_DONE     = 0;
    localparam int IS_ERRSUM   = 15;
    localparam int ES_TMO      = 0;
    localparam int ES_CRC      = 1;
    localparam int ES_IDX      = 3;

    typedef enum logic [1:0] {
        RSP_NONE       = 2'b00,
        RSP_LONG       = 2'b01,
        RSP_SHORT      = 2'b10,
        RSP_SHORT_BUSY = 2'b11
    } rsp_kind_e;

    typedef struct packed {
        logic [1:0]       rsv_hi;
        logic [IDX_W-1:0] index;
        logic [1:0]       rsv_mid;
        logic             data_sel;
        logic             idx_chk;
        logic             crc_chk;
        logic             rsv_lo;
        rsp_kind_e        kind;
    } cmd_word_t;

    typedef struct packed {
        logic [IDX_W-1:0] index;
        logic             data_sel;
        logic             idx_chk;
        logic             crc_chk;
        rsp_kind_e        kind;
    } cmd_lat_t;

    typedef enum logic [1:0] {C_IDLE, C_SEND, C_RESP} ctl_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_RECV} rx_state_e;

    function automatic logic [CRC_W-1:0] crc7_calc(input logic [CRC_SPAN-1:0] bits);
        logic [CRC_W-1:0] c;
        logic fb;
        c = '0;
        for (int i = CRC_SPAN - 1; i >= 0; i--) begin
            fb = bits[i] ^ c[CRC_W-1];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
    import sdcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] index,
    input  logic [ARG_W-1:0] arg,
    output logic             busy,
    output logic             done,
    output logic             bit_out
);
    localparam int CNT_W = $clog2(SHORT_W);

    logic [SHORT_W-1:0]  sh_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                busy_q;
    logic                done_q;
    logic [CRC_SPAN-1:0] head_w;

    assign head_w = {2'b01, index, arg};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                sh_q   <= {head_w, crc7_calc(head_w), 1'b1};
                cnt_q  <= CNT_W'(SHORT_W - 1);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                sh_q <= {sh_q[SHORT_W-2:0], 1'b0};
                if (cnt_q == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign bit_out = busy_q ? sh_q[SHORT_W-1] : 1'b1;

    // R3: the controller never restarts a frame in flight
    a_r3_no_restart: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);
    // R1: the first bit on the line is the 0 start bit
    a_r1_start_bit: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> !bit_out);

endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
    import sdcmd_pkg::*;
#(
    parameter int TMO_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              long_sel,
    input  logic              line_in,
    output logic [LONG_W-1:0] frame,
    output logic              done,
    output logic              timeout
);
    localparam int TMO_W = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;
    localparam int BIT_W = $clog2(LONG_W);

    rx_state_e         st_q;
    logic [TMO_W-1:0]  wcnt_q;
    logic [BIT_W-1:0]  bcnt_q;
    logic [LONG_W-1:0] frame_q;
    logic              long_q;
    logic              done_q;
    logic              tmo_q;
    logic [BIT_W-1:0]  last_w;

    assign last_w = long_q ? BIT_W'(LONG_W - 1) : BIT_W'(SHORT_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= RX_IDLE;
            wcnt_q  <= '0;
            bcnt_q  <= '0;
            frame_q <= '0;
            long_q  <= 1'b0;
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
            case (st_q)
                RX_IDLE: if (start) begin
                    st_q   <= RX_WAIT;
                    wcnt_q <= '0;
                    long_q <= long_sel;
                end
                RX_WAIT: begin
                    if (!line_in) begin
                        st_q    <= RX_RECV;
                        frame_q <= '0;
                        bcnt_q  <= BIT_W'(1);
                    end else if (wcnt_q == TMO_W'(TMO_CYCLES - 1)) begin
                        st_q  <= RX_IDLE;
                        tmo_q <= 1'b1;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                RX_RECV: begin
                    frame_q <= {frame_q[LONG_W-2:0], line_in};
                    bcnt_q  <= bcnt_q + 1'b1;
                    if (bcnt_q == last_w) begin
                        st_q   <= RX_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st_q <= RX_IDLE;
            endcase
        end
    end

    assign frame   = frame_q;
    assign done    = done_q;
    assign timeout = tmo_q;

    // R8: the wait for a start bit never runs past the window
    a_r8_wait_bound: assert property (@(posedge clk) disable iff (rst)
        (st_q == RX_WAIT) |-> (int'(wcnt_q) < TMO_CYCLES));

endmodule

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer
    import sdcmd_pkg::*;
#(
    parameter int TMO_CYCLES = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arg_we,
    input  logic [31:0]  arg_wdata,
    input  logic         cmd_we,
    input  logic [15:0]  cmd_wdata,
    input  logic         int_clr_we,
    input  logic [15:0]  int_clr,
    input  logic         err_clr_we,
    input  logic [15:0]  err_clr,
    input  logic         cmd_in,
    input  logic         dat0_in,
    output logic         cmd_out,
    output logic [31:0]  present_state,
    output logic [15:0]  int_status,
    output logic [15:0]  err_status,
    output logic [127:0] response
);
    cmd_word_t         cmd_w;
    cmd_lat_t          cmd_q;
    ctl_state_e        st_q;
    logic [ARG_W-1:0]  arg_q;
    logic [RSP_W-1:0]  rsp_q;
    logic              dat_busy_q, busy_wait_q;
    logic              done_q, tmo_q, crc_err_q, idx_err_q;

    logic              accept, busy_nodata_w;
    logic              tx_busy, tx_done;
    logic              rx_start, rx_done, rx_tmo;
    logic [LONG_W-1:0] rx_frame;
    logic              is_long, idx_bad, crc_bad, set_done;
    logic              clr_done, clr_tmo, clr_crc, clr_idx;

    assign cmd_w         = cmd_word_t'(cmd_wdata);
    assign busy_nodata_w = (cmd_w.kind == RSP_SHORT_BUSY) && !cmd_w.data_sel;
    assign accept        = cmd_we && (st_q == C_IDLE) && !(busy_nodata_w && dat_busy_q);

    sdcmd_tx u_tx (
        .clk(clk), .rst(rst), .start(accept), .index(cmd_w.index), .arg(arg_q),
        .busy(tx_busy), .done(tx_done), .bit_out(cmd_out)
    );

    assign rx_start = tx_done && (cmd_q.kind != RSP_NONE);

    sdcmd_rx #(.TMO_CYCLES(TMO_CYCLES)) u_rx (
        .clk(clk), .rst(rst), .start(rx_start), .long_sel(cmd_q.kind == RSP_LONG),
        .line_in(cmd_in), .frame(rx_frame), .done(rx_done), .timeout(rx_tmo)
    );

    // reply checks apply to 48-bit replies only
    assign is_long  = (cmd_q.kind == RSP_LONG);
    assign idx_bad  = !is_long && cmd_q.idx_chk && (rx_frame[45:40] != cmd_q.index);
    assign crc_bad  = !is_long && cmd_q.crc_chk &&
                      (rx_frame[7:1] != crc7_calc(rx_frame[SHORT_W-1:8]));
    assign set_done = (tx_done && cmd_q.kind == RSP_NONE) || rx_done;

    assign clr_done = int_clr_we && int_clr[IS_DONE];
    assign clr_tmo  = err_clr_we && err_clr[ES_TMO];
    assign clr_crc  = err_clr_we && err_clr[ES_CRC];
    assign clr_idx  = err_clr_we && err_clr[ES_IDX];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= C_IDLE;
            cmd_q       <= '0;
            arg_q       <= '0;
            rsp_q       <= '0;
            dat_busy_q  <= 1'b0;
            busy_wait_q <= 1'b0;
            done_q      <= 1'b0;
            tmo_q       <= 1'b0;
            crc_err_q   <= 1'b0;
            idx_err_q   <= 1'b0;
        end else begin
            if (arg_we) arg_q <= arg_wdata;
            case (st_q)
                C_IDLE: if (accept) begin
                    cmd_q <= '{index: cmd_w.index, data_sel: cmd_w.data_sel,
                               idx_chk: cmd_w.idx_chk, crc_chk: cmd_w.crc_chk,
                               kind: cmd_w.kind};
                    st_q  <= C_SEND;
                    if (busy_nodata_w) dat_busy_q <= 1'b1;
                end
                C_SEND: if (tx_done) st_q <= (cmd_q.kind == RSP_NONE) ? C_IDLE : C_RESP;
                C_RESP: if (rx_done || rx_tmo) st_q <= C_IDLE;
                default: st_q <= C_IDLE;
            endcase
            if (rx_done) begin
                rsp_q <= is_long ? {8'h00, rx_frame[RSP_W-1:8]}
                                 : {{(RSP_W-ARG_W){1'b0}}, rx_frame[39:8]};
                if (cmd_q.kind == RSP_SHORT_BUSY && !cmd_q.data_sel) busy_wait_q <= 1'b1;
            end
            if (rx_tmo) dat_busy_q <= 1'b0;
            if (busy_wait_q && dat0_in) begin
                busy_wait_q <= 1'b0;
                dat_busy_q  <= 1'b0;
            end
            done_q    <= set_done              | (done_q    & ~clr_done);
            tmo_q     <= rx_tmo                | (tmo_q     & ~clr_tmo);
            crc_err_q <= (rx_done && crc_bad)  | (crc_err_q & ~clr_crc);
            idx_err_q <= (rx_done && idx_bad)  | (idx_err_q & ~clr_idx);
        end
    end

    always_comb begin
        present_state              = '0;
        present_state[PS_CMD_BUSY] = (st_q != C_IDLE);
        present_state[PS_DAT_BUSY] = dat_busy_q;
        present_state[PS_DAT0]     = dat0_in;
        err_status                 = '0;
        err_status[ES_TMO]         = tmo_q;
        err_status[ES_CRC]         = crc_err_q;
        err_status[ES_IDX]         = idx_err_q;
        int_status                 = '0;
        int_status[IS_DONE]        = done_q;
        int_status[IS_ERRSUM]      = tmo_q | crc_err_q | idx_err_q;
    end

    assign response = rsp_q;

    logic unused_bits;
    assign unused_bits = ^{cmd_w.rsv_hi, cmd_w.rsv_mid, cmd_w.rsv_lo, rx_frame[LONG_W-1:RSP_W],
                           rx_frame[0], int_clr[15:1], err_clr[15:4], err_clr[2], tx_busy};

    // R7: data busy is released only by a high data line 0 or a timeout
    a_r7_dat_release: assert property (@(posedge clk) disable iff (rst)
        $fell(dat_busy_q) |-> ($past(dat0_in) || $past(rx_tmo)));
    // R5: a reply can only finish while the controller waits for one
    a_r5_reply_in_resp: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> (st_q == C_RESP));
    // R3: a write during a command leaves the latched command untouched
    a_r3_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && st_q != C_IDLE) |=> $stable(cmd_q));
    // R8: timeout and reply completion never coincide
    a_r8_tmo_excl: assert property (@(posedge clk) disable iff (rst)
        rx_tmo |-> !rx_done);

endmodule

// File: tb/sim_sd_cmd_issuer.sv
module sim_sd_cmd_issuer;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         arg_we = 1'b0, cmd_we = 1'b0, int_clr_we = 1'b0, err_clr_we = 1'b0;
    logic [31:0]  arg_wdata = '0;
    logic [15:0]  cmd_wdata = '0, int_clr = '0, err_clr = '0;
    logic         cmd_in = 1'b1, dat0_in = 1'b1;
    logic         cmd_out;
    logic [31:0]  present_state;
    logic [15:0]  int_status, err_status;
    logic [127:0] response;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sd_cmd_issuer u0 (
        .clk(clk), .rst(rst), .arg_we(arg_we), .arg_wdata(arg_wdata),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .int_clr_we(int_clr_we), .int_clr(int_clr),
        .err_clr_we(err_clr_we), .err_clr(err_clr), .cmd_in(cmd_in), .dat0_in(dat0_in),
        .cmd_out(cmd_out), .present_state(present_state), .int_status(int_status),
        .err_status(err_status), .response(response)
    );

    typedef struct packed {
        logic [15:0] cmd;
        logic [31:0] arg;
        logic [2:0]  mode;   // 0 none,1 good,2 wrong index,3 bad crc,4 long,5 silent
        logic [7:0]  gap;
        logic        dup;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{16'h0000, 32'h0000_0000, 3'd0, 8'd3,  1'b1},
        '{16'h081A, 32'h0000_01AA, 3'd1, 8'd3,  1'b0},
        '{16'h111A, 32'h0000_1000, 3'd2, 8'd3,  1'b0},
        '{16'h0D1A, 32'h0001_0000, 3'd3, 8'd5,  1'b0},
        '{16'h0901, 32'h1234_0000, 3'd4, 8'd4,  1'b0},
        '{16'h371A, 32'hDEAD_BEEF, 3'd5, 8'd3,  1'b0},
        '{16'h1002, 32'h0F0F_0F0F, 3'd2, 8'd3,  1'b0},
        '{16'h071A, 32'h8000_0001, 3'd1, 8'd60, 1'b0}
    };

    function automatic logic [6:0] ref_crc(input logic [39:0] d);
        logic [6:0] r = '0;
        logic inv;
        for (int k = 39; k >= 0; k--) begin
            inv  = d[k] ^ r[6];
            r[6] = r[5]; r[5] = r[4]; r[4] = r[3];
            r[3] = r[2] ^ inv;
            r[2] = r[1]; r[1] = r[0]; r[0] = inv;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        int_clr_we = 1'b1; int_clr = 16'hFFFF; err_clr_we = 1'b1; err_clr = 16'hFFFF;
        @(negedge clk);
        int_clr_we = 1'b0; err_clr_we = 1'b0;
    endtask

    // issue a command, capture its frame, then answer per mode
    task automatic do_cmd(input logic [15:0] cmd, input logic [31:0] arg,
                          input logic [2:0] mode, input int gap, input bit dup);
        logic [47:0]  got, exp_f;
        logic [135:0] rf;
        logic [39:0]  head;
        int           len;
        @(negedge clk);
        arg_we = 1'b1; arg_wdata = arg;
        @(negedge clk);
        arg_we = 1'b0; cmd_we = 1'b1; cmd_wdata = cmd;
        @(negedge clk);
        cmd_we = 1'b0;
        for (int i = 0; i < 48; i++) begin
            got[47-i] = cmd_out;
            if (i == 0) check(present_state[0] == 1'b1, "R3 cmd busy on accept",
                              128'(present_state[0]), 128'd1);
            if (i == 0 && dup) begin cmd_we = 1'b1; cmd_wdata = 16'h2A1A; end
            if (i == 1) cmd_we = 1'b0;
            @(negedge clk);
        end
        head  = {2'b01, cmd[13:8], arg};
        exp_f = {head, ref_crc(head), 1'b1};
        check(got == exp_f, "R1 R2 command frame", 128'(got), 128'(exp_f));
        if (mode == 3'd0) begin
            check(present_state[0] == 1'b1 && int_status[0] == 1'b0, "R4 still busy at end bit",
                  128'({present_state[0], int_status[0]}), 128'b10);
            @(negedge clk);
            check(present_state[0] == 1'b0 && int_status[0] == 1'b1, "R4 done after end bit",
                  128'({present_state[0], int_status[0]}), 128'b01);
        end else if (mode != 3'd5) begin
            if (mode == 3'd4) begin
                rf  = {8'h3F, 24'hABCDEF, arg, ~arg, arg ^ 32'h5A5A_5A5A, 7'h55, 1'b1};
                len = 136;
            end else begin
                logic [39:0] rh;
                logic [6:0]  rc;
                rh = {2'b00, (mode == 3'd2) ? (cmd[13:8] ^ 6'h01) : cmd[13:8],
                      arg ^ 32'hC0DE_0001};
                rc = ref_crc(rh) ^ ((mode == 3'd3) ? 7'h01 : 7'h00);
                rf  = {88'h0, rh, rc, 1'b1};
                len = 48;
            end
            repeat (gap - 1) @(negedge clk);
            for (int j = len - 1; j >= 0; j--) begin
                cmd_in = rf[j];
                @(negedge clk);
            end
            cmd_in = 1'b1;
        end
        for (int w = 0; w < 200 && present_state[0]; w++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [127:0] exp_rsp = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(cmd_out == 1'b1, "R12 cmd_out idle", 128'(cmd_out), 128'd1);
        check(present_state == 32'h0010_0000, "R12 present state", 128'(present_state),
              128'h0010_0000);
        check(int_status == 0 && err_status == 0, "R12 status zero",
              128'({int_status, err_status}), 128'd0);
        check(response == 0, "R12 response zero", response, 128'd0);
        // R2 known CRC value
        check(ref_crc(40'h40_0000_0000) == 7'h4A, "R2 reference crc", 
              128'(ref_crc(40'h40_0000_0000)), 128'h4A);

        for (int v = 0; v < NVEC; v++) begin
            vec_t t;
            logic [15:0] exp_err;
            bit exp_done;
            t = VECS[v];
            do_cmd(t.cmd, t.arg, t.mode, int'(t.gap), t.dup);
            exp_err = (t.mode == 3'd2 && t.cmd[4]) ? 16'h0008 :   // R9
                      (t.mode == 3'd3 && t.cmd[3]) ? 16'h0002 :   // R10
                      (t.mode == 3'd5)             ? 16'h0001 :   // R8
                                                     16'h0000;
            exp_done = (t.mode != 3'd5);
            if (t.mode inside {3'd1, 3'd2, 3'd3}) exp_rsp = {96'h0, t.arg ^ 32'hC0DE_0001};
            if (t.mode == 3'd4)
                exp_rsp = {8'h00, 24'hABCDEF, t.arg, ~t.arg, t.arg ^ 32'h5A5A_5A5A};
            check(present_state[1:0] == 2'b00, $sformatf("R3 R8 inhibits clear v%0d", v),
                  128'(present_state[1:0]), 128'd0);
            check(err_status == exp_err, $sformatf("R8 R9 R10 error bits v%0d", v),
                  128'(err_status), 128'(exp_err));
            check(int_status[0] == exp_done, $sformatf("R4 R5 R8 complete v%0d", v),
                  128'(int_status[0]), 128'(exp_done));
            check(response == exp_rsp, $sformatf("R5 R6 response v%0d", v), response, exp_rsp);
            if (t.dup) begin
                bit quiet = 1'b1;
                for (int q = 0; q < 60; q++) begin
                    if (cmd_out != 1'b1 || present_state[0]) quiet = 1'b0;
                    @(negedge clk);
                end
                check(quiet, "R3 no second frame", 128'(quiet), 128'd1);
            end
            // R11 clear completion only, summary must follow errors
            @(negedge clk);
            int_clr_we = 1'b1; int_clr = 16'h8001;
            @(negedge clk);
            int_clr_we = 1'b0;
            check(int_status == {(exp_err != 0), 15'h0}, $sformatf("R11 partial clear v%0d", v),
                  128'(int_status), 128'({(exp_err != 0), 15'h0}));
            clear_all();
            check(int_status == 0 && err_status == 0, $sformatf("R11 full clear v%0d", v),
                  128'({int_status, err_status}), 128'd0);
        end

        // R7 busy reply without data
        dat0_in = 1'b0;
        @(negedge clk);
        check(present_state[20] == 1'b0, "R7 dat0 mirror low", 128'(present_state[20]), 128'd0);
        do_cmd(16'h0C1B, 32'h0000_0C0C, 3'd1, 3, 1'b0);
        check(present_state[1:0] == 2'b10 && int_status[0], "R7 data busy held",
              128'({present_state[1:0], int_status[0]}), 128'b101);
        check(response == {96'h0, 32'h0000_0C0C ^ 32'hC0DE_0001}, "R5 busy reply payload",
              response, {96'h0, 32'h0000_0C0C ^ 32'hC0DE_0001});
        // a second busy command is refused while data busy
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = 16'h071B;
        @(negedge clk);
        cmd_we = 1'b0;
        begin
            bit idle = 1'b1;
            for (int q = 0; q < 10; q++) begin
                if (cmd_out != 1'b1 || present_state[0]) idle = 1'b0;
                @(negedge clk);
            end
            check(idle, "R7 busy command refused", 128'(idle), 128'd1);
        end
        check(present_state[1] == 1'b1, "R7 still busy before release",
              128'(present_state[1]), 128'd1);
        dat0_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(present_state[1] == 1'b0 && present_state[20] == 1'b1, "R7 released on dat0 high",
              128'({present_state[1], present_state[20]}), 128'b01);
        clear_all();
        // R7 busy type with data present does not raise data busy
        dat0_in = 1'b0;
        do_cmd(16'h0C3B, 32'h0000_0001, 3'd1, 3, 1'b0);
        check(present_state[1] == 1'b0, "R7 data-present skips data busy",
              128'(present_state[1]), 128'd0);
        dat0_in = 1'b1;
        clear_all();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule